// File: doc/BRIEF.md
# Interrupt Entry State Save Unit

This block performs the state bookkeeping needed when a core accepts an interrupt. On an accepted take strobe it stores the address of the instruction that would have run next into one save register. It stores the full machine-state word into a second save register. It then produces the rewritten machine-state word and a 32-bit handler address with a one-cycle valid pulse, and the fetch unit redirects to that address.

The handler address is formed from a 16-bit vector base input, a 12-bit offset held in a small table with one entry per interrupt cause, and four zero bits, so every handler starts on a 16-byte boundary. The table accepts a 16-bit word on write and keeps only its upper 12 bits. On entry, three enable bits of the machine state keep their values: critical, machine-check and debug. Every other bit is cleared. This includes the external-enable bit, which gates the take, so a second interrupt cannot be accepted until software sets that bit again.

Top module: `irq_entry_save`

## Requirements
- R1: While reset is held and right after it, `redir_vld_o` is 0 and `save_pc_o`, `save_ms_o`, `ms_new_o`, `redir_addr_o` and every offset table readback are all 0.
- R2: A take is accepted when `take_i`=1, `block_i`=0 and `ms_i[15]` (external enable)=1 at a rising edge. `redir_vld_o` is then 1 for exactly the following cycle. Back-to-back accepted takes give one valid cycle each.
- R3: After an accepted take, `save_pc_o` equals the `nia_i` value present at the take.
- R4: After an accepted take, `save_ms_o` equals the complete `ms_i` value present at the take.
- R5: After an accepted take, `ms_new_o` keeps `ms_i` bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) and has every other bit 0, including bit 15.
- R6: After an accepted take, `redir_addr_o` is `vec_base_i[15:0]`, then bits [15:4] of the offset entry chosen by `take_idx_i`, then four 0 bits (MSB first).
- R7: A take strobe while `block_i`=1 is ignored: there is no valid pulse, and the save registers, `ms_new_o` and `redir_addr_o` keep their values.
- R8: A take strobe while `ms_i[15]`=0 is ignored in the same way as in R7.
- R9: An offset table write stores `ofs_wdata_i[15:4]`. `ofs_rdata_o` for the selected entry returns those bits with bits [3:0] reading 0.
- R10: Without an accepted take, the save registers, `ms_new_o` and `redir_addr_o` hold their last values.
- R11: A take in the same cycle as a write to the entry it selects uses the offset stored before that write. The new offset is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Take strobe for the pending interrupt |
| take_idx_i | input | 2 | Offset table entry of the interrupt being taken |
| block_i | input | 1 | A higher-priority exception is pending |
| nia_i | input | 32 | Address of the next instruction to execute |
| ms_i | input | 32 | Current machine-state word |
| vec_base_i | input | 16 | Handler vector base (upper address bits) |
| ofs_we_i | input | 1 | Offset table write enable |
| ofs_idx_i | input | 2 | Offset table entry for write and readback |
| ofs_wdata_i | input | 16 | Offset write word; bits [3:0] discarded |
| ofs_rdata_o | output | 16 | Readback of entry `ofs_idx_i`, bits [3:0] zero |
| save_pc_o | output | 32 | Saved next-instruction address |
| save_ms_o | output | 32 | Saved machine-state word |
| ms_new_o | output | 32 | Machine-state word after entry |
| redir_addr_o | output | 32 | Handler fetch address |
| redir_vld_o | output | 1 | One-cycle pulse marking a new handler address |

## Verification
The bound checker watches every cycle for the following properties. Each accepted take is followed by exactly one valid cycle, and rejected strobes give none. The saved values equal the inputs from the cycle before. The rewritten state never carries a bit outside the three kept enables, and the state holds still when no take is accepted. The checker also confirms that the handler address has the vector base on top and a 16-byte-aligned bottom, and that offset readback has zero low bits. Only the bench scenarios can show that the right table entry is chosen by index, that a same-cycle write leaves the take with the old offset, and that the stored offsets really drop the low nibble of the written word.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   // machine-state word width and default positions of its enable bits
   localparam int unsigned MS_W_DEF      = 32;
   localparam int unsigned CRIT_EN_POS   = 17;
   localparam int unsigned EXT_EN_POS    = 15;
   localparam int unsigned MCHK_EN_POS   = 12;
   localparam int unsigned DBG_EN_POS    = 9;

   // handler address composition
   localparam int unsigned VBASE_W_DEF   = 16;
   localparam int unsigned OFS_WORD_DEF  = 16;
   localparam int unsigned ALIGN_W_DEF   = 4;
   localparam int unsigned NUM_VEC_DEF   = 4;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_ms_rewrite.sv
module irq_ms_rewrite #(
   parameter int unsigned MS_W     = irq_entry_pkg::MS_W_DEF,
   parameter int unsigned KEEP_A   = irq_entry_pkg::CRIT_EN_POS,
   parameter int unsigned KEEP_B   = irq_entry_pkg::MCHK_EN_POS,
   parameter int unsigned KEEP_C   = irq_entry_pkg::DBG_EN_POS
) (
   input  logic [MS_W-1:0] ms_i,
   output logic [MS_W-1:0] ms_o
);

   // per-bit choice: kept bits pass through, all others are forced low
   for (genvar b = 0; b < MS_W; b++) begin : g_bit
      if (b == KEEP_A || b == KEEP_B || b == KEEP_C) begin : g_keep
         assign ms_o[b] = ms_i[b];
      end else begin : g_clear
         assign ms_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
   parameter int unsigned NUM_VEC  = irq_entry_pkg::NUM_VEC_DEF,
   parameter int unsigned WORD_W   = irq_entry_pkg::OFS_WORD_DEF,
   parameter int unsigned ALIGN_W  = irq_entry_pkg::ALIGN_W_DEF,
   localparam int unsigned IDX_W   = irq_entry_pkg::idx_width(NUM_VEC),
   localparam int unsigned STORE_W = WORD_W - ALIGN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   widx_i,
   input  logic [WORD_W-1:0]  wdata_i,
   input  logic [IDX_W-1:0]   ridx_i,
   output logic [WORD_W-1:0]  rdata_o,
   input  logic [IDX_W-1:0]   tidx_i,
   output logic [STORE_W-1:0] tofs_o
);

   logic [STORE_W-1:0] ent [NUM_VEC];
   logic               unused_low;

   // low alignment bits of the write word are never stored
   assign unused_low = ^wdata_i[ALIGN_W-1:0];

   for (genvar e = 0; e < NUM_VEC; e++) begin : g_ent
      logic [STORE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we_i && (widx_i == IDX_W'(e))) begin
            q <= wdata_i[WORD_W-1:ALIGN_W];
         end
      end
      assign ent[e] = q;
   end

   always_comb begin
      rdata_o = '0;
      tofs_o  = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (ridx_i == IDX_W'(i)) rdata_o = {ent[i], {ALIGN_W{1'b0}}};
         if (tidx_i == IDX_W'(i)) tofs_o  = ent[i];
      end
   end

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MS_W   = irq_entry_pkg::MS_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [ADDR_W-1:0] nia_i,
   input  logic [MS_W-1:0]   ms_i,
   input  logic [MS_W-1:0]   ms_new_i,
   input  logic [ADDR_W-1:0] vec_i,
   output logic [ADDR_W-1:0] save_pc_o,
   output logic [MS_W-1:0]   save_ms_o,
   output logic [MS_W-1:0]   ms_new_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic              vld_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         save_pc_o <= '0;
         save_ms_o <= '0;
         ms_new_o  <= '0;
         vec_o     <= '0;
         vld_o     <= 1'b0;
      end else begin
         vld_o <= cap_i;
         if (cap_i) begin
            save_pc_o <= nia_i;
            save_ms_o <= ms_i;
            ms_new_o  <= ms_new_i;
            vec_o     <= vec_i;
         end
      end
   end

endmodule

// File: rtl/irq_entry_save.sv
module irq_entry_save #(
   parameter int unsigned MS_W     = irq_entry_pkg::MS_W_DEF,
   parameter int unsigned VBASE_W  = irq_entry_pkg::VBASE_W_DEF,
   parameter int unsigned OFS_WORD = irq_entry_pkg::OFS_WORD_DEF,
   parameter int unsigned ALIGN_W  = irq_entry_pkg::ALIGN_W_DEF,
   parameter int unsigned NUM_VEC  = irq_entry_pkg::NUM_VEC_DEF,
   parameter int unsigned CE_POS   = irq_entry_pkg::CRIT_EN_POS,
   parameter int unsigned ME_POS   = irq_entry_pkg::MCHK_EN_POS,
   parameter int unsigned DE_POS   = irq_entry_pkg::DBG_EN_POS,
   parameter int unsigned EE_POS   = irq_entry_pkg::EXT_EN_POS,
   localparam int unsigned IDX_W   = irq_entry_pkg::idx_width(NUM_VEC),
   localparam int unsigned OFS_W   = OFS_WORD - ALIGN_W,
   localparam int unsigned ADDR_W  = VBASE_W + OFS_W + ALIGN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [IDX_W-1:0]   take_idx_i,
   input  logic               block_i,
   input  logic [ADDR_W-1:0]  nia_i,
   input  logic [MS_W-1:0]    ms_i,
   input  logic [VBASE_W-1:0] vec_base_i,
   input  logic               ofs_we_i,
   input  logic [IDX_W-1:0]   ofs_idx_i,
   input  logic [OFS_WORD-1:0] ofs_wdata_i,
   output logic [OFS_WORD-1:0] ofs_rdata_o,
   output logic [ADDR_W-1:0]  save_pc_o,
   output logic [MS_W-1:0]    save_ms_o,
   output logic [MS_W-1:0]    ms_new_o,
   output logic [ADDR_W-1:0]  redir_addr_o,
   output logic               redir_vld_o
);

   // elaboration-time parameter checks
   if (CE_POS >= MS_W || ME_POS >= MS_W || DE_POS >= MS_W || EE_POS >= MS_W) begin : g_bad_pos
      $error("irq_entry_save: enable bit position outside machine-state word");
   end
   if (EE_POS == CE_POS || EE_POS == ME_POS || EE_POS == DE_POS) begin : g_ee_kept
      $error("irq_entry_save: external enable must not be a preserved bit");
   end
   if (OFS_WORD <= ALIGN_W) begin : g_bad_ofs
      $error("irq_entry_save: offset word narrower than alignment");
   end
   if (NUM_VEC < 1) begin : g_bad_num
      $error("irq_entry_save: offset table needs at least one entry");
   end

   logic               take_ok;
   logic [OFS_W-1:0]   take_ofs;
   logic [MS_W-1:0]    ms_entry;
   logic [ADDR_W-1:0]  vec_addr;

   assign take_ok  = take_i & ~block_i & ms_i[EE_POS];
   assign vec_addr = {vec_base_i, take_ofs, {ALIGN_W{1'b0}}};

   irq_vec_table #(
      .NUM_VEC (NUM_VEC),
      .WORD_W  (OFS_WORD),
      .ALIGN_W (ALIGN_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ofs_we_i),
      .widx_i  (ofs_idx_i),
      .wdata_i (ofs_wdata_i),
      .ridx_i  (ofs_idx_i),
      .rdata_o (ofs_rdata_o),
      .tidx_i  (take_idx_i),
      .tofs_o  (take_ofs)
   );

   irq_ms_rewrite #(
      .MS_W   (MS_W),
      .KEEP_A (CE_POS),
      .KEEP_B (ME_POS),
      .KEEP_C (DE_POS)
   ) u_rewrite (
      .ms_i (ms_i),
      .ms_o (ms_entry)
   );

   irq_save_bank #(
      .ADDR_W (ADDR_W),
      .MS_W   (MS_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (take_ok),
      .nia_i     (nia_i),
      .ms_i      (ms_i),
      .ms_new_i  (ms_entry),
      .vec_i     (vec_addr),
      .save_pc_o (save_pc_o),
      .save_ms_o (save_ms_o),
      .ms_new_o  (ms_new_o),
      .vec_o     (redir_addr_o),
      .vld_o     (redir_vld_o)
   );

endmodule

// File: rtl/irq_entry_save_chk.sv
module irq_entry_save_chk #(
   parameter int unsigned MS_W     = 32,
   parameter int unsigned VBASE_W  = 16,
   parameter int unsigned OFS_WORD = 16,
   parameter int unsigned ALIGN_W  = 4,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned CE_POS   = 17,
   parameter int unsigned ME_POS   = 12,
   parameter int unsigned DE_POS   = 9,
   parameter int unsigned EE_POS   = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic                take_i,
   input logic                block_i,
   input logic [ADDR_W-1:0]   nia_i,
   input logic [MS_W-1:0]     ms_i,
   input logic [VBASE_W-1:0]  vec_base_i,
   input logic [OFS_WORD-1:0] ofs_rdata_o,
   input logic [ADDR_W-1:0]   save_pc_o,
   input logic [MS_W-1:0]     save_ms_o,
   input logic [MS_W-1:0]     ms_new_o,
   input logic [ADDR_W-1:0]   redir_addr_o,
   input logic                redir_vld_o
);

   localparam logic [MS_W-1:0] KEEP =
      (MS_W'(1) << CE_POS) | (MS_W'(1) << ME_POS) | (MS_W'(1) << DE_POS);

   logic acc;
   assign acc = take_i && !block_i && ms_i[EE_POS];

   // R2
   pulse_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> redir_vld_o);

   // R7 R8
   no_pulse_if_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !redir_vld_o);

   // R3
   pc_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> save_pc_o == $past(nia_i));

   // R4
   ms_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> save_ms_o == $past(ms_i));

   // R5
   ms_only_kept_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_new_o & ~KEEP) == '0);

   // R5
   ms_kept_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (ms_new_o & KEEP) == ($past(ms_i) & KEEP));

   // R6
   vec_base_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> redir_addr_o[ADDR_W-1 -: VBASE_W] == $past(vec_base_i));

   // R6
   vec_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_addr_o[ALIGN_W-1:0] == '0);

   // R9
   rdata_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_rdata_o[ALIGN_W-1:0] == '0);

   // R10
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(save_pc_o) && $stable(save_ms_o) && $stable(ms_new_o)
               && $stable(redir_addr_o));

endmodule

bind irq_entry_save irq_entry_save_chk #(
   .MS_W     (MS_W),
   .VBASE_W  (VBASE_W),
   .OFS_WORD (OFS_WORD),
   .ALIGN_W  (ALIGN_W),
   .ADDR_W   (ADDR_W),
   .CE_POS   (CE_POS),
   .ME_POS   (ME_POS),
   .DE_POS   (DE_POS),
   .EE_POS   (EE_POS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .take_i       (take_i),
   .block_i      (block_i),
   .nia_i        (nia_i),
   .ms_i         (ms_i),
   .vec_base_i   (vec_base_i),
   .ofs_rdata_o  (ofs_rdata_o),
   .save_pc_o    (save_pc_o),
   .save_ms_o    (save_ms_o),
   .ms_new_o     (ms_new_o),
   .redir_addr_o (redir_addr_o),
   .redir_vld_o  (redir_vld_o)
);

// File: tb/irq_entry_save_bench.sv
`timescale 1ns/1ps
module irq_entry_save_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [1:0]  take_idx_i = '0;
   logic        block_i = 1'b0;
   logic [31:0] nia_i = '0;
   logic [31:0] ms_i = '0;
   logic [15:0] vec_base_i = '0;
   logic        ofs_we_i = 1'b0;
   logic [1:0]  ofs_idx_i = '0;
   logic [15:0] ofs_wdata_i = '0;
   logic [15:0] ofs_rdata_o;
   logic [31:0] save_pc_o, save_ms_o, ms_new_o, redir_addr_o;
   logic        redir_vld_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_entry_save u_irq_entry_save (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_idx_i(take_idx_i),
      .block_i(block_i), .nia_i(nia_i), .ms_i(ms_i), .vec_base_i(vec_base_i),
      .ofs_we_i(ofs_we_i), .ofs_idx_i(ofs_idx_i), .ofs_wdata_i(ofs_wdata_i),
      .ofs_rdata_o(ofs_rdata_o), .save_pc_o(save_pc_o), .save_ms_o(save_ms_o),
      .ms_new_o(ms_new_o), .redir_addr_o(redir_addr_o), .redir_vld_o(redir_vld_o)
   );

   // model state, built from the requirements
   localparam logic [31:0] KEEP_M = (32'h1 << 17) | (32'h1 << 12) | (32'h1 << 9);
   logic [15:0] ofs_m [4];
   logic [31:0] e_pc = '0, e_ms = '0, e_new = '0, e_addr = '0;

   typedef struct packed {
      logic [31:0] nia;
      logic [31:0] ms;
      logic [15:0] vb;
      logic [1:0]  idx;
      logic        blk;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{32'h1000_0004, 32'hFFFF_FFFF, 16'hFFFF, 2'd2, 1'b0},
      '{32'h0000_2000, 32'h0000_8000, 16'h0000, 2'd0, 1'b0},
      '{32'hDEAD_BEE8, 32'h0002_8200, 16'h8000, 2'd1, 1'b1},
      '{32'h1234_5678, 32'h7FFF_7FFF, 16'h1111, 2'd3, 1'b0},
      '{32'hCAFE_0010, 32'h0002_9200, 16'h8000, 2'd1, 1'b0},
      '{32'h0000_0044, 32'h0000_9000, 16'h1234, 2'd3, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " save_pc"},  save_pc_o,    e_pc);
      chk({req, " save_ms"},  save_ms_o,    e_ms);
      chk({req, " ms_new"},   ms_new_o,     e_new);
      chk({req, " redir"},    redir_addr_o, e_addr);
   endtask

   // apply one take attempt at a negedge; check one cycle later
   task automatic attempt(input vec_t v, input string req);
      logic acc;
      @(negedge clk);
      take_i = 1'b1; nia_i = v.nia; ms_i = v.ms; vec_base_i = v.vb;
      take_idx_i = v.idx; block_i = v.blk;
      acc = !v.blk && v.ms[15];
      if (acc) begin
         e_pc = v.nia; e_ms = v.ms; e_new = v.ms & KEEP_M;
         e_addr = {v.vb, ofs_m[v.idx][15:4], 4'b0000};
      end
      @(negedge clk);
      take_i = 1'b0; block_i = 1'b0;
      chk({req, " vld"}, {31'd0, redir_vld_o}, {31'd0, acc});
      chk_state(req);
      @(negedge clk);
      chk({req, " vld drop"}, {31'd0, redir_vld_o}, 32'd0);
   endtask

   task automatic wr_ofs(input logic [1:0] idx, input logic [15:0] w);
      @(negedge clk);
      ofs_we_i = 1'b1; ofs_idx_i = idx; ofs_wdata_i = w;
      ofs_m[idx] = w & 16'hFFF0;
      @(negedge clk);
      ofs_we_i = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 4; i++) ofs_m[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state while held
      chk("R1 vld in reset", {31'd0, redir_vld_o}, 32'd0);
      chk_state("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         ofs_idx_i = 2'(i);
         #0.1;
         chk("R1 table after reset", {16'd0, ofs_rdata_o}, 32'd0);
      end

      // R9 table writes and readback
      wr_ofs(2'd0, 16'h0500);
      wr_ofs(2'd1, 16'h0A3F);
      wr_ofs(2'd2, 16'hFFF7);
      wr_ofs(2'd3, 16'h1238);
      for (int i = 0; i < 4; i++) begin
         ofs_idx_i = 2'(i);
         #0.1;
         chk("R9 readback", {16'd0, ofs_rdata_o}, {16'd0, ofs_m[i]});
      end

      // R2 R3 R4 R5 R6 R7 R8 R10 vector walk
      for (int k = 0; k < 6; k++) begin
         attempt(VECS[k], VECS[k].blk ? "R7" : (VECS[k].ms[15] ? "R2 R3 R4 R5 R6" : "R8"));
      end

      // R10 idle cycles hold state
      repeat (3) @(negedge clk);
      chk_state("R10 idle hold");

      // R2 back-to-back takes give two valid cycles
      @(negedge clk);
      take_i = 1'b1; ms_i = 32'h0000_8200; nia_i = 32'h0000_0100;
      vec_base_i = 16'h4000; take_idx_i = 2'd0;
      @(negedge clk);
      chk("R2 b2b first vld", {31'd0, redir_vld_o}, 32'd1);
      chk("R2 b2b first addr", redir_addr_o, {16'h4000, ofs_m[0][15:4], 4'h0});
      nia_i = 32'h0000_0200; take_idx_i = 2'd3;
      @(negedge clk);
      take_i = 1'b0;
      chk("R2 b2b second vld", {31'd0, redir_vld_o}, 32'd1);
      chk("R3 b2b second pc", save_pc_o, 32'h0000_0200);
      chk("R6 b2b second addr", redir_addr_o, {16'h4000, ofs_m[3][15:4], 4'h0});
      @(negedge clk);
      chk("R2 b2b drop", {31'd0, redir_vld_o}, 32'd0);

      // R11 write and take to the same entry in one cycle
      @(negedge clk);
      ofs_we_i = 1'b1; ofs_idx_i = 2'd1; ofs_wdata_i = 16'h7775;
      take_i = 1'b1; take_idx_i = 2'd1; ms_i = 32'h0000_8000; vec_base_i = 16'h00AA;
      @(negedge clk);
      ofs_we_i = 1'b0; take_i = 1'b0;
      chk("R11 old offset used", redir_addr_o, {16'h00AA, ofs_m[1][15:4], 4'h0});
      ofs_m[1] = 16'h7770;
      #0.1;
      chk("R11 new offset visible", {16'd0, ofs_rdata_o}, {16'd0, ofs_m[1]});

      // R1 reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 mid-run reset pc", save_pc_o, 32'd0);
      chk("R1 mid-run reset redir", redir_addr_o, 32'd0);
      chk("R1 mid-run reset table", {16'd0, ofs_rdata_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule